// File: doc/BRIEF.md
# Line Wake-Up Pulse Detector

This block watches the communication line of a sensor transceiver for a wake-up request. A request shows up as the line output staying shorted. The analog side reports a short through two flags: one for a short while the driver sources current, one for a short while it sinks current. The driver mode picks which flags count. A short counts as a wake-up only once it has lasted through a false-wake-up blanking interval and then the nominal 80 us qualification time. After that the block drives an active-low wake-up output for 200 us. In register mode it also emits a one-cycle event for the interrupt logic.

All timing is counted in clock cycles from a parameter giving clock cycles per microsecond. In pin mode the blanking interval is fixed at 128 us and detection cannot be switched off. In register mode a two-bit setting selects the blanking interval, and a disable bit turns detection off. After a detection the short must go away before the line can be detected again. A short that qualifies while a pulse is still running is dropped.

Top module: `lwu_detector`

## Requirements
- R1: `wuPulseN` falls on the clock edge at which the qualifying short has been sampled high on N consecutive edges, where N = (blanking us + QUAL_US) * CLK_MHZ, and it never falls without a qualifying short.
- R2: When `regMode` = 0, the blanking time is 128 us whatever the value of `blankSel`.
- R3: When `regMode` = 1, `blankSel` values 0, 1, 2 and 3 select 64, 128, 256 and 512 us of blanking.
- R4: Once it has fallen, `wuPulseN` stays low for exactly PULSE_US * CLK_MHZ cycles and then returns high.
- R5: `lineShort[0]` flags a short while sourcing and `lineShort[1]` a short while sinking. For `drvMode` 0 (push-pull) or 3, either bit qualifies. For 1 (high-side) only bit 0 qualifies. For 2 (low-side) only bit 1 qualifies.
- R6: If the qualifying short drops for even one sampled cycle before qualification, the count restarts from zero.
- R7: With `regMode` = 1 and `wuDis` = 1 no detection occurs. With `regMode` = 0 `wuDis` has no effect.
- R8: `irqEvt` is high for exactly one cycle, in the cycle in which `wuPulseN` first goes low, and only if `regMode` was 1 at detection. It stays low in pin mode.
- R9: After a detection the qualifying short must be released before another detection. A short that qualifies while `wuPulseN` is low produces no pulse and no event.
- R10: While and after `rst` is high, `wuPulseN` is 1 and `irqEvt` is 0. This includes a reset that arrives in the middle of a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lineShort | input | 2 | Short flags: bit 0 while sourcing, bit 1 while sinking |
| drvMode | input | 2 | Driver mode: 0 push-pull, 1 high-side, 2 low-side, 3 push-pull |
| regMode | input | 1 | 1 = register mode, 0 = pin mode |
| blankSel | input | 2 | Blanking select, used in register mode only |
| wuDis | input | 1 | Detection disable, used in register mode only |
| wuPulseN | output | 1 | Active-low wake-up pulse |
| irqEvt | output | 1 | One-cycle wake-up interrupt event |

## Verification
The bench aims at the exact qualification edge. It checks one cycle short of the limit and exactly at the limit, so a counter that is off by one fires a cycle early or misses the threshold. It drives the short flag of the wrong polarity for each driver mode, sets the disable bit in both modes, and feeds a blankSel value that pin mode must ignore. A design that mixed up the mode gating or the table of blanking codes would fire where no pulse is expected. It also holds the short long after a detection, re-qualifies a short inside a running pulse, and briefly interrupts a short before it qualifies. A design without re-arming would pulse repeatedly, and one that kept counting through the gap would fire early.

// File: rtl/lwu_pkg.sv
package lwu_pkg;

  typedef enum logic [1:0] {
    DRV_PUSHPULL = 2'd0,
    DRV_HIGHSIDE = 2'd1,
    DRV_LOWSIDE  = 2'd2,
    DRV_PP_ALT   = 2'd3
  } drvMode_e;

  // strobes from the control to the datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
    logic fire;
  } lwuStrobe_t;

endpackage

// File: rtl/lwu_datapath.sv
module lwu_datapath
  import lwu_pkg::*;
#(
  parameter int CLK_MHZ        = 250,
  parameter int QUAL_US        = 80,
  parameter int PULSE_US       = 200,
  parameter int BLANK_BASE_US  = 64,
  parameter int PIN_BLANK_CODE = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  lwuStrobe_t strobe,
  input  logic       regMode,
  input  logic [1:0] blankSel,
  output logic       qualHit,
  output logic       pulseActive,
  output logic       wuPulseN
);

  localparam int NUM_CODES  = 4;
  localparam int MAX_TARGET = ((BLANK_BASE_US << (NUM_CODES - 1)) + QUAL_US) * CLK_MHZ;
  localparam int CNT_W      = $clog2(MAX_TARGET + 1);
  localparam int PULSE_CYC  = PULSE_US * CLK_MHZ;
  localparam int PW         = $clog2(PULSE_CYC + 1);

  logic [CNT_W-1:0] targetTab [NUM_CODES];
  logic [CNT_W-1:0] shortCnt;
  logic [PW-1:0]    pulseLeft;
  logic [1:0]       blankCode;

  // last count value before qualification, one entry per blanking code
  for (genvar g = 0; g < NUM_CODES; g++) begin : g_target
    assign targetTab[g] = CNT_W'(((BLANK_BASE_US << g) + QUAL_US) * CLK_MHZ - 1);
  end

  assign blankCode = regMode ? blankSel : 2'(PIN_BLANK_CODE);
  assign qualHit   = shortCnt >= targetTab[blankCode];

  always_ff @(posedge clk) begin
    if (rst || strobe.cntClr) begin
      shortCnt <= '0;
    end else if (strobe.cntInc) begin
      shortCnt <= shortCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulseLeft <= '0;
    end else if (strobe.fire) begin
      pulseLeft <= PW'(PULSE_CYC);
    end else if (pulseLeft != '0) begin
      pulseLeft <= pulseLeft - PW'(1);
    end
  end

  assign pulseActive = pulseLeft != '0;
  assign wuPulseN    = ~pulseActive;

endmodule

// File: rtl/lwu_ctrl.sv
module lwu_ctrl
  import lwu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] lineShort,
  input  logic [1:0] drvMode,
  input  logic       regMode,
  input  logic       wuDis,
  input  logic       qualHit,
  input  logic       pulseActive,
  output lwuStrobe_t strobe,
  output logic       irqEvt
);

  logic effShort;
  logic detectOn;
  logic armed;
  logic live;
  logic hit;

  always_comb begin
    unique case (drvMode_e'(drvMode))
      DRV_HIGHSIDE: effShort = lineShort[0];
      DRV_LOWSIDE:  effShort = lineShort[1];
      default:      effShort = |lineShort;
    endcase
  end

  assign detectOn = ~(regMode & wuDis);
  assign live     = effShort & detectOn & armed;
  assign hit      = live & qualHit;

  assign strobe.fire   = hit & ~pulseActive;
  assign strobe.cntInc = live & ~qualHit;
  assign strobe.cntClr = ~live | qualHit;

  // re-arm only once the short has gone away
  always_ff @(posedge clk) begin
    if (rst || !effShort) begin
      armed <= 1'b1;
    end else if (hit) begin
      armed <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irqEvt <= 1'b0;
    end else begin
      irqEvt <= strobe.fire & regMode;
    end
  end

endmodule

// File: rtl/lwu_detector.sv
module lwu_detector
  import lwu_pkg::*;
#(
  parameter int CLK_MHZ        = 250,
  parameter int QUAL_US        = 80,
  parameter int PULSE_US       = 200,
  parameter int BLANK_BASE_US  = 64,
  parameter int PIN_BLANK_CODE = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] lineShort,
  input  logic [1:0] drvMode,
  input  logic       regMode,
  input  logic [1:0] blankSel,
  input  logic       wuDis,
  output logic       wuPulseN,
  output logic       irqEvt
);

  lwuStrobe_t strobe;
  logic       qualHit;
  logic       pulseActive;

  lwu_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .lineShort   (lineShort),
    .drvMode     (drvMode),
    .regMode     (regMode),
    .wuDis       (wuDis),
    .qualHit     (qualHit),
    .pulseActive (pulseActive),
    .strobe      (strobe),
    .irqEvt      (irqEvt)
  );

  lwu_datapath #(
    .CLK_MHZ        (CLK_MHZ),
    .QUAL_US        (QUAL_US),
    .PULSE_US       (PULSE_US),
    .BLANK_BASE_US  (BLANK_BASE_US),
    .PIN_BLANK_CODE (PIN_BLANK_CODE)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .regMode     (regMode),
    .blankSel    (blankSel),
    .qualHit     (qualHit),
    .pulseActive (pulseActive),
    .wuPulseN    (wuPulseN)
  );

endmodule

// File: rtl/lwu_checker.sv
module lwu_checker #(
  parameter int PULSE_CYC = 50000
) (
  input logic       clk,
  input logic       rst,
  input logic [1:0] lineShort,
  input logic       regMode,
  input logic       wuDis,
  input logic       wuPulseN,
  input logic       irqEvt
);

  int lowCnt;

  always_ff @(posedge clk) begin
    if (rst || wuPulseN) begin
      lowCnt <= 0;
    end else begin
      lowCnt <= lowCnt + 1;
    end
  end

  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wuPulseN) |-> lowCnt == PULSE_CYC);

  // R8
  irq_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(wuPulseN) && $past(regMode)) |-> irqEvt);

  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irqEvt |=> !irqEvt);

  // R8
  irq_reg_only_chk: assert property (@(posedge clk) disable iff (rst)
    irqEvt |-> (!wuPulseN && $past(regMode)));

  // R7
  disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (regMode && wuDis) |=> !$fell(wuPulseN));

  // R1
  needs_short_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wuPulseN) |-> $past(lineShort != 2'b00));

endmodule

bind lwu_detector lwu_checker #(
  .PULSE_CYC (PULSE_US * CLK_MHZ)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .lineShort (lineShort),
  .regMode   (regMode),
  .wuDis     (wuDis),
  .wuPulseN  (wuPulseN),
  .irqEvt    (irqEvt)
);

// File: tb/sim_lwu_detector.sv
module sim_lwu_detector;

  localparam int MHZ   = 1;
  localparam int QUAL  = 80;
  localparam int PULSE = 200;
  localparam int BASE  = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] lineShort = 2'b00;
  logic [1:0] drvMode = 2'd0;
  logic       regMode = 1'b0;
  logic [1:0] blankSel = 2'd0;
  logic       wuDis = 1'b0;
  logic       wuPulseN;
  logic       irqEvt;

  int runCnt = 0;
  int failCnt = 0;
  int fallCnt = 0;
  logic prevN = 1'b1;

  always #2 clk = ~clk;

  lwu_detector #(
    .CLK_MHZ        (MHZ),
    .QUAL_US        (QUAL),
    .PULSE_US       (PULSE),
    .BLANK_BASE_US  (BASE),
    .PIN_BLANK_CODE (1)
  ) u0 (
    .clk       (clk),
    .rst       (rst),
    .lineShort (lineShort),
    .drvMode   (drvMode),
    .regMode   (regMode),
    .blankSel  (blankSel),
    .wuDis     (wuDis),
    .wuPulseN  (wuPulseN),
    .irqEvt    (irqEvt)
  );

  // falling edges of the wake-up output, seen away from the active edge
  always @(negedge clk) begin
    if (prevN && !wuPulseN) fallCnt <= fallCnt + 1;
    prevN <= wuPulseN;
  end

  typedef struct packed {
    logic        rm;
    logic        dis;
    logic [1:0]  bl;
    logic [1:0]  drv;
    logic [1:0]  sh;
    logic [15:0] hold;
    logic        expFire;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 2'd3, 2'd0, 2'b01, 16'd300, 1'b1},  // R2 pin mode, blankSel ignored
    '{1'b1, 1'b0, 2'd0, 2'd0, 2'b10, 16'd200, 1'b1},  // R3 code 0
    '{1'b1, 1'b0, 2'd1, 2'd1, 2'b01, 16'd250, 1'b1},  // R3 code 1, R5 high-side
    '{1'b1, 1'b0, 2'd2, 2'd2, 2'b10, 16'd400, 1'b1},  // R3 code 2, R5 low-side
    '{1'b1, 1'b0, 2'd3, 2'd3, 2'b11, 16'd650, 1'b1},  // R3 code 3
    '{1'b1, 1'b0, 2'd0, 2'd1, 2'b10, 16'd300, 1'b0},  // R5 wrong flag high-side
    '{1'b1, 1'b0, 2'd0, 2'd2, 2'b01, 16'd300, 1'b0},  // R5 wrong flag low-side
    '{1'b1, 1'b1, 2'd0, 2'd0, 2'b01, 16'd300, 1'b0},  // R7 disabled
    '{1'b0, 1'b1, 2'd0, 2'd0, 2'b01, 16'd300, 1'b1},  // R7 pin mode ignores disable
    '{1'b1, 1'b0, 2'd0, 2'd0, 2'b01, 16'd143, 1'b0},  // R1 one short of limit
    '{1'b1, 1'b0, 2'd0, 2'd0, 2'b01, 16'd144, 1'b1}   // R1 exactly at limit
  };

  function automatic int targetOf(input logic rm, input logic [1:0] bl);
    int code = rm ? int'(bl) : 1;
    return ((BASE << code) + QUAL) * MHZ;
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int expv);
    runCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic runVec(input vec_t v, input int idx);
    int detAt = -1;
    int irqAtDet = 0;
    int lowSamples = 0;
    int irqSamples = 0;
    int expAt;
    @(negedge clk);
    lineShort = 2'b00;
    regMode = v.rm; wuDis = v.dis; blankSel = v.bl; drvMode = v.drv;
    idle(5);
    expAt = targetOf(v.rm, v.bl);
    lineShort = v.sh;
    for (int i = 1; i <= int'(v.hold); i++) begin
      @(negedge clk);
      if (!wuPulseN) lowSamples++;
      if (irqEvt) irqSamples++;
      if (!wuPulseN && detAt < 0) begin
        detAt = i;
        irqAtDet = int'(irqEvt);
      end
    end
    lineShort = 2'b00;
    for (int i = 0; i < PULSE * MHZ + 20; i++) begin
      @(negedge clk);
      if (!wuPulseN) lowSamples++;
      if (irqEvt) irqSamples++;
    end
    check((detAt >= 0) == v.expFire, $sformatf("R1 R5 R7 vec%0d fired", idx),
          int'(detAt >= 0), int'(v.expFire));
    if (v.expFire) begin
      check(detAt == expAt, $sformatf("R1 R2 R3 vec%0d detect cycle", idx), detAt, expAt);
      check(lowSamples == PULSE * MHZ, $sformatf("R4 vec%0d pulse width", idx),
            lowSamples, PULSE * MHZ);
      check(irqAtDet == int'(v.rm), $sformatf("R8 vec%0d irq at detect", idx),
            irqAtDet, int'(v.rm));
      check(irqSamples == int'(v.rm), $sformatf("R8 vec%0d irq cycles", idx),
            irqSamples, int'(v.rm));
    end else begin
      check(lowSamples == 0, $sformatf("R7 vec%0d no pulse", idx), lowSamples, 0);
      check(irqSamples == 0, $sformatf("R8 vec%0d no irq", idx), irqSamples, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL R10 watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

  initial begin
    int f0;
    int t;
    idle(4);
    // R10 reset state
    check(wuPulseN == 1'b1, "R10 reset wuPulseN", int'(wuPulseN), 1);
    check(irqEvt == 1'b0, "R10 reset irqEvt", int'(irqEvt), 0);
    rst = 1'b0;
    idle(2);

    for (int k = 0; k < NV; k++) runVec(VECS[k], k);

    // R9 long hold gives one pulse only
    regMode = 1'b1; wuDis = 1'b0; blankSel = 2'd0; drvMode = 2'd0;
    f0 = fallCnt;
    lineShort = 2'b01;
    idle(700);
    lineShort = 2'b00;
    idle(10);
    check(fallCnt - f0 == 1, "R9 held short single pulse", fallCnt - f0, 1);

    // R9 qualifying inside a running pulse is dropped, re-arm needs release
    f0 = fallCnt;
    lineShort = 2'b01;
    idle(150);
    lineShort = 2'b00;
    idle(2);
    lineShort = 2'b01;
    idle(250);
    check(fallCnt - f0 == 1, "R9 detection during pulse ignored", fallCnt - f0, 1);
    lineShort = 2'b00;
    idle(3);
    lineShort = 2'b01;
    idle(150);
    check(fallCnt - f0 == 2, "R9 re-armed after release", fallCnt - f0, 2);
    lineShort = 2'b00;
    idle(PULSE * MHZ + 10);

    // R6 a one-cycle gap restarts qualification
    lineShort = 2'b01;
    idle(100);
    lineShort = 2'b00;
    idle(1);
    lineShort = 2'b01;
    t = 0;
    for (int i = 1; i <= 200; i++) begin
      @(negedge clk);
      if (!wuPulseN && t == 0) t = i;
    end
    check(t == targetOf(1'b1, 2'd0), "R6 count restarts after gap", t, targetOf(1'b1, 2'd0));
    lineShort = 2'b00;
    idle(PULSE * MHZ + 10);

    // R10 reset in the middle of a pulse
    lineShort = 2'b01;
    idle(150);
    lineShort = 2'b00;
    check(wuPulseN == 1'b0, "R10 pulse active before reset", int'(wuPulseN), 0);
    rst = 1'b1;
    idle(2);
    check(wuPulseN == 1'b1, "R10 reset clears pulse", int'(wuPulseN), 1);
    check(irqEvt == 1'b0, "R10 reset clears irq", int'(irqEvt), 0);
    rst = 1'b0;
    idle(5);
    check(wuPulseN == 1'b1, "R10 idle after reset", int'(wuPulseN), 1);

    $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

endmodule